// File: doc/BRIEF.md
# Dual-Edge Pin Event Latch with Combined Interrupt

This block watches six asynchronous general-purpose input lines and records any level change on each of them, rising or falling, in a sticky event bit. Each line is brought into the clock domain by a two-flop synchronizer. A change is detected by comparing the synchronized level with its value one clock earlier. An event bit stays set until software clears it by writing a one to its position. A write of zero leaves the bit unchanged.

A per-source enable register gates the event bits onto one active-low interrupt line. That line is driven from a register, so it cannot glitch. Software reaches both registers through a byte-wide synchronous register port. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `edge_irq_agg`

## Requirements
- R1: A rising transition on `gpin[i]` sets event bit i. Bit i of the event register is tied to pin i. The bit reads as 1 at address 0 after the third rising clock edge that follows the pin change.
- R2: A falling transition on `gpin[i]` sets event bit i, with the same latency as R1.
- R3: A write to address 0 clears every event bit whose `reg_wdata` bit is 1. Event bits whose `reg_wdata` bit is 0 are left unchanged. A set bit that is not cleared stays set.
- R4: Bits 7 and 6 of the event register always read 0 and ignore writes.
- R5: If a detected change on pin i falls on the same clock edge as a write-one clear of bit i, bit i stays set.
- R6: After reset, the event register and the enable register are both 0x00 and `irq_n` is 1.
- R7: The enable register is at address 1. All eight bits can be written and read back. Bit i (i = 0..5) enables event bit i, where 1 enables and 0 blocks. Bits 6 and 7 have no effect on `irq_n`.
- R8: `irq_n` is 0 on the clock after any event bit is set while its enable bit is 1. Otherwise it is 1.
- R9: Reads of address 2 or 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| gpin | input | 6 | Asynchronous monitored pins |
| reg_addr | input | 2 | Register address: 0 is event status, 1 is enable |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The bench toggles single pins up and then down, which tells a detector that sees both edges apart from one that sees only one edge. It also sets bit patterns that touch every position, which exposes swapped or shifted bit mapping. A clear is timed to land on the same edge as a fresh change, which separates a design where the set wins from one where the clear wins. A long random phase mixes pin activity with writes of random data, addresses and enables. That phase shows whether the enable masking and the one-cycle interrupt latency hold on every clock.

// File: rtl/edge_irq_agg.sv
module edge_irq_agg #(
  parameter int NSRC   = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   gpin,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);

  logic [NSRC-1:0]   pin_meta, pin_sync, pin_prev;
  logic [NSRC-1:0]   edge_hit, clr_mask, status_q;
  logic [DATA_W-1:0] enable_q;

  assign edge_hit = pin_sync ^ pin_prev;
  assign clr_mask = (reg_we && reg_addr == A_STAT) ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_meta <= '0;
      pin_sync <= '0;
      pin_prev <= '0;
      status_q <= '0;
      enable_q <= '0;
      irq_n    <= 1'b1;
    end else begin
      pin_meta <= gpin;
      pin_sync <= pin_meta;
      pin_prev <= pin_sync;
      status_q <= (status_q & ~clr_mask) | edge_hit;
      if (reg_we && reg_addr == A_EN) enable_q <= reg_wdata;
      irq_n    <= ~|(status_q & enable_q[NSRC-1:0]);
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {{(DATA_W-NSRC){1'b0}}, status_q};
      A_EN:    reg_rdata = enable_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/edge_irq_agg_chk.sv
module edge_irq_agg_chk #(
  parameter int NSRC   = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_n,
  input logic [NSRC-1:0]   edge_hit,
  input logic [NSRC-1:0]   status_q,
  input logic [DATA_W-1:0] enable_q
);
  logic stat_wr;
  assign stat_wr = reg_we && reg_addr == '0;

  always_comb begin
    if (!rst_n) begin
      p_reset_clear_r6: assert (status_q == '0 && enable_q == '0);
    end
  end

  p_rsv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == '0 |-> reg_rdata[DATA_W-1:NSRC] == '0);

  p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    |edge_hit |=> (status_q & $past(edge_hit)) == $past(edge_hit));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (status_q & $past(reg_wdata[NSRC-1:0] & ~edge_hit)) == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (status_q & $past(status_q)) == $past(status_q));

  p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |(status_q & enable_q[NSRC-1:0]) |=> !irq_n);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_q & enable_q[NSRC-1:0])) |=> irq_n);
endmodule

bind edge_irq_agg edge_irq_agg_chk #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n),
  .edge_hit(edge_hit), .status_q(status_q), .enable_q(enable_q)
);

// File: tb/edge_irq_agg_tb.sv
module edge_irq_agg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] gpin = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .gpin(gpin), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // reference model: pin history queue, sticky events, enable, irq
  int         hist[$];
  logic [5:0] m_st;
  logic [7:0] m_en;
  logic       m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {0, 0, 0};
      m_st = '0; m_en = '0; m_irq = 1'b1;
    end else begin
      logic [5:0] chg;
      chg = 6'(hist[hist.size()-2]) ^ 6'(hist[hist.size()-3]);
      m_irq = ~|(m_st & m_en[5:0]);
      if (reg_we && reg_addr == 2'd0) m_st = m_st & ~reg_wdata[5:0];
      m_st = m_st | chg;
      if (reg_we && reg_addr == 2'd1) m_en = reg_wdata;
      hist.push_back(int'(gpin));
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {2'b00, m_st};
      2'd1: return m_en;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({7'd0, irq_n}, {7'd0, m_irq}, "R8 model irq_n");
      check(reg_rdata, m_read(reg_addr), "R1/R2/R3/R7/R9 model rdata");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rd_at_neg(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    @(negedge clk);
    check(reg_rdata, exp, req);
    step(1);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check({7'd0, irq_n}, 8'd1, "R6 irq_n in reset");
    step(3);
    rst_n = 1'b1;
    step(1);
    rd_at_neg(2'd0, 8'h00, "R6 status after reset");
    rd_at_neg(2'd1, 8'h00, "R6 enable after reset");

    // rising edge on pin 3
    gpin = 6'b001000;
    step(3);
    rd_at_neg(2'd0, 8'h08, "R1 rising sets bit 3");
    wr(2'd0, 8'h08);
    rd_at_neg(2'd0, 8'h00, "R3 write-one clears bit 3");

    // falling edge on pin 3
    gpin = 6'b000000;
    step(3);
    rd_at_neg(2'd0, 8'h08, "R2 falling sets bit 3");

    // zero write leaves bits, reserved bits stay 0
    wr(2'd0, 8'hC0);
    rd_at_neg(2'd0, 8'h08, "R3 zero write keeps bit 3 and R4 reserved read 0");
    gpin = 6'b110101;
    step(4);
    rd_at_neg(2'd0, 8'h3D, "R1 multi-pin mapping");
    wr(2'd0, 8'hFF);
    rd_at_neg(2'd0, 8'h00, "R4 status reads 0 in bits 7:6 after 0xFF write");

    // enable: only bits 6/7 set -> no irq
    wr(2'd1, 8'hC0);
    rd_at_neg(2'd1, 8'hC0, "R7 enable readback");
    gpin = 6'b110100;
    step(4);
    @(negedge clk);
    check({7'd0, irq_n}, 8'd1, "R7 bits 7:6 do not raise irq");
    step(1);
    wr(2'd1, 8'h01);
    step(1);
    @(negedge clk);
    check({7'd0, irq_n}, 8'd0, "R8 enabled event drives irq low");
    step(1);
    wr(2'd0, 8'h01);
    step(1);
    @(negedge clk);
    check({7'd0, irq_n}, 8'd1, "R8 irq released after clear");
    step(1);

    // simultaneous edge and clear on bit 0
    gpin = 6'b110101;
    step(3);
    gpin = 6'b110100;
    step(2);
    reg_addr = 2'd0; reg_we = 1'b1; reg_wdata = 8'h01;
    step(1);
    reg_we = 1'b0;
    rd_at_neg(2'd0, 8'h01, "R5 edge wins over same-cycle clear");
    wr(2'd0, 8'h01);
    rd_at_neg(2'd0, 8'h00, "R3 later clear succeeds");

    rd_at_neg(2'd2, 8'h00, "R9 addr 2 reads 0");
    rd_at_neg(2'd3, 8'h00, "R9 addr 3 reads 0");

    // random phase, compared every clock against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) gpin = 6'($urandom);
      reg_addr = 2'($urandom);
      reg_we = ($urandom_range(0, 4) == 0);
      reg_wdata = 8'($urandom);
      step(1);
    end
    reg_we = 1'b0;
    step(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule